// File: doc/BRIEF.md
# Serial NOR Flash Target with Auto-Increment Programming

This block is a synthesizable model of a serial NOR flash on the target side of an SPI mode-0 link, holding its data in a small internal byte array. The host lowers the chip select, clocks an opcode byte in most-significant bit first, and adds three address bytes where the command needs them. Data bytes then go into the array, or stream back out on the serial output. All serial pins are brought into the system clock domain and their edges are found there, so the serial clock must run well below the system clock.

Six commands are served: set and clear the write-enable latch, read status, read data, program a page, and a sticky auto-increment programming mode. The first auto-increment opcode takes an address and forces it even. Each later one carries on from where the previous burst stopped, with no new address. While that mode is active, opcodes outside a small legal set pulse an error output for one system clock, and so does a blocked attempt to enter the mode. Programming can only clear bits. The array comes out of reset as all ones.

Top module: `serial_flash_target`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears both the latch and the auto-increment mode flag. Opcode 0x05 returns the status byte on every following byte of the command: bit 1 is the latch, bit 6 is the mode flag, and all other bits are 0.
- R3: Opcode 0x03, followed by a 24-bit address sent MSB first, streams array bytes starting at that address. Address bits above the array depth are ignored, and the address wraps from the top of the array to 0.
- R4: Opcode 0x02 with the latch set takes a 24-bit address and then programs one byte per data byte. Each stored byte becomes old AND new. The address advances modulo the depth, and the latch clears when chip select rises.
- R5: A program attempt while the latch is clear leaves the array unchanged.
- R6: Opcode 0xAD with the latch clear is ignored and raises the error pulse.
- R7: The first 0xAD with the latch set and the mode inactive sets the mode flag and collects a 24-bit address. It then programs from that address with bit 0 cleared.
- R8: A 0xAD while the mode is active collects no address. Its data bytes program at the address that follows the last byte of the previous burst.
- R9: While the mode is active, any opcode other than 0xAD, 0x04 or 0x05 raises the error pulse, which lasts one system clock.
- R10: In the auto-increment mode, programming the last array byte clears both the latch and the mode flag. Further data bytes in that command write nothing.
- R11: Raising chip select ends any command. The next byte after chip select falls again is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| seq_err | output | 1 | One-clock pulse on an illegal command sequence |

## Verification
Each serial edge reaches the decoder after the synchronizer stages plus one edge-detect register, which is three system clocks with the default of two stages. MISO therefore settles one clock later, after a falling SCK, and the error pulse appears on the same edge that completes the offending opcode. The bench holds every SCK level for six system clocks and reads MISO just before it raises SCK, so each bit is taken well after it has settled. Array and status results are checked in later read transactions, after chip select has been high for several clocks. Error pulses are counted continuously and compared against the expected total after each transaction.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_AINC = 8'hAD;

    localparam int ADDR_BYTES = 3;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_PROG,
        ST_STAT,
        ST_READ,
        ST_SKIP
    } dec_state_t;

    typedef enum logic [1:0] {
        K_READ,
        K_PAGE,
        K_AINC
    } cmd_kind_t;

    function automatic logic [7:0] status_byte(input logic wel, input logic ainc);
        return {1'b0, ainc, 4'b0000, wel, 1'b0};
    endfunction

    function automatic logic ainc_legal(input logic [7:0] op);
        return (op == OP_AINC) || (op == OP_WRDI) || (op == OP_RDSR);
    endfunction

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_end,
    output logic mosi_s
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b010; // {mosi, cs_n, sck}

    logic [NPIN-1:0] stage_q [STAGES];
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] pins_s;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= IDLE_LVL;
                else if (s == 0) stage_q[s] <= {mosi, cs_n, sck};
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign pins_s = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LVL;
        else     prev_q <= pins_s;
    end

    assign sck_rise = pins_s[0] & ~prev_q[0];
    assign sck_fall = ~pins_s[0] & prev_q[0];
    assign cs_act   = ~pins_s[1];
    assign cs_end   = pins_s[1] & ~prev_q[1];
    assign mosi_s   = pins_s[2];

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    assign rdata = mem[addr];

    // R4: a program step can only clear bits of the addressed byte
    a_r4_and_only: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(addr)] == ($past(rdata) & $past(wdata))));

    logic [AW-1:0] unused_chk;
    assign unused_chk = addr;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sck_rise,
    input  logic                     sck_fall,
    input  logic                     cs_act,
    input  logic                     cs_end,
    input  logic                     mosi_s,
    output logic                     miso,
    output logic                     err_pulse,
    output logic                     mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_addr,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    dec_state_t  state;
    cmd_kind_t   kind;
    logic [2:0]  bit_cnt;
    logic [6:0]  rx_q;
    logic [15:0] addr_sh;
    logic [1:0]  addr_cnt;
    logic [AW-1:0] cur;
    logic        wel, ainc, page_armed, load_rd;
    logic [7:0]  tx_q;

    logic        byte_done;
    logic [7:0]  byte_in;
    logic [23:0] full_addr;
    logic [AW-1:0] start_addr;

    assign byte_done  = cs_act && sck_rise && (bit_cnt == 3'd7);
    assign byte_in    = {rx_q, mosi_s};
    assign full_addr  = {addr_sh, byte_in};
    assign start_addr = full_addr[AW-1:0];

    assign mem_addr  = cur;
    assign mem_wdata = byte_in;
    assign mem_we    = byte_done && (state == ST_PROG) && wel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OPCODE;
            kind       <= K_READ;
            bit_cnt    <= '0;
            rx_q       <= '0;
            addr_sh    <= '0;
            addr_cnt   <= '0;
            cur        <= '0;
            wel        <= 1'b0;
            ainc       <= 1'b0;
            page_armed <= 1'b0;
            load_rd    <= 1'b0;
            tx_q       <= '0;
            miso       <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            load_rd   <= 1'b0;
            if (!cs_act) begin
                state   <= ST_OPCODE;
                bit_cnt <= '0;
                if (cs_end) begin
                    if (page_armed) wel <= 1'b0;
                    page_armed <= 1'b0;
                end
            end else begin
                if (sck_fall) begin
                    miso <= tx_q[7];
                    tx_q <= {tx_q[6:0], 1'b0};
                end
                if (sck_rise) begin
                    rx_q    <= byte_in[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (byte_done) begin
                    case (state)
                        ST_OPCODE: begin
                            if (ainc && !ainc_legal(byte_in)) err_pulse <= 1'b1;
                            addr_cnt <= '0;
                            state    <= ST_SKIP;
                            case (byte_in)
                                OP_WREN: wel <= 1'b1;
                                OP_WRDI: begin
                                    wel  <= 1'b0;
                                    ainc <= 1'b0;
                                end
                                OP_RDSR: begin
                                    tx_q  <= status_byte(wel, ainc);
                                    state <= ST_STAT;
                                end
                                OP_READ: begin
                                    kind  <= K_READ;
                                    state <= ST_ADDR;
                                end
                                OP_PROG: begin
                                    if (wel) begin
                                        kind       <= K_PAGE;
                                        page_armed <= 1'b1;
                                        state      <= ST_ADDR;
                                    end
                                end
                                OP_AINC: begin
                                    if (!wel) begin
                                        err_pulse <= 1'b1;
                                    end else if (ainc) begin
                                        state <= ST_PROG;
                                    end else begin
                                        ainc  <= 1'b1;
                                        kind  <= K_AINC;
                                        state <= ST_ADDR;
                                    end
                                end
                                default: state <= ST_SKIP;
                            endcase
                        end
                        ST_ADDR: begin
                            addr_sh  <= {addr_sh[7:0], byte_in};
                            addr_cnt <= addr_cnt + 2'd1;
                            if (addr_cnt == 2'(ADDR_BYTES - 1)) begin
                                case (kind)
                                    K_READ: begin
                                        cur     <= start_addr;
                                        load_rd <= 1'b1;
                                        state   <= ST_READ;
                                    end
                                    K_AINC: begin
                                        cur   <= {start_addr[AW-1:1], 1'b0};
                                        state <= ST_PROG;
                                    end
                                    default: begin
                                        cur   <= start_addr;
                                        state <= ST_PROG;
                                    end
                                endcase
                            end
                        end
                        ST_PROG: begin
                            if (wel) begin
                                cur <= cur + 1'b1;
                                if (ainc && cur == TOP_ADDR) begin
                                    wel  <= 1'b0;
                                    ainc <= 1'b0;
                                end
                            end
                        end
                        ST_STAT: tx_q <= status_byte(wel, ainc);
                        ST_READ: load_rd <= 1'b1;
                        default: ;
                    endcase
                end
            end
            if (load_rd) begin
                tx_q <= mem_rdata;
                cur  <= cur + 1'b1;
            end
        end
    end

    // R9: the error indication never lasts longer than one clock
    a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    // R10: programming the top byte in auto-increment mode ends the mode
    a_r10_top_abort: assert property (@(posedge clk) disable iff (rst)
        (mem_we && ainc && cur == TOP_ADDR) |=> (!wel && !ainc));

    // R7: the first auto-increment burst starts on an even address
    a_r7_even_start: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_ADDR && kind == K_AINC && addr_cnt == 2'(ADDR_BYTES - 1))
        |=> (state == ST_PROG && cur[0] == 1'b0));

    // R2: write disable leaves neither the latch nor the mode set
    a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_OPCODE && byte_in == OP_WRDI) |=> (!wel && !ainc));

    // R6: a blocked auto-increment opcode does not change the mode flag
    a_r6_blocked_ainc: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_OPCODE && byte_in == OP_AINC && !wel) |=> $stable(ainc));

    // R11: chip select high returns the decoder to opcode collection
    a_r11_cs_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (state == ST_OPCODE && bit_cnt == 3'd0));

    // R5: nothing is written while the latch is clear
    a_r5_no_write_locked: assert property (@(posedge clk) disable iff (rst)
        (!wel && !cs_act) |=> !mem_we);

endmodule

// File: rtl/serial_flash_target.sv
module serial_flash_target #(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic seq_err
);
    localparam int AW = $clog2(DEPTH);

    logic sck_rise, sck_fall, cs_act, cs_end, mosi_s;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    flash_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_end   (cs_end),
        .mosi_s   (mosi_s)
    );

    flash_cmd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_act    (cs_act),
        .cs_end    (cs_end),
        .mosi_s    (mosi_s),
        .miso      (miso),
        .err_pulse (seq_err),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    flash_byte_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/test_serial_flash_target.sv
module test_serial_flash_target;
    localparam int DEPTH = 64;
    localparam int HALF = 6;
    localparam int NBUF = 72;
    localparam logic [7:0] HI_BITS = 8'(256 - DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, seq_err;

    logic [7:0] model [DEPTH];
    logic [7:0] txb [NBUF];
    logic [7:0] rxb [NBUF];
    int vectors = 0;
    int miscompares = 0;
    int err_seen = 0;
    int err_exp = 0;
    bit finished = 1'b0;

    serial_flash_target #(.DEPTH(DEPTH)) i_serial_flash_target (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .seq_err(seq_err)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (!rst && seq_err) err_seen++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int n);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = txb[b][i];
                wait_clk(HALF);
                rxb[b][i] = miso;
                sck = 1'b1;
                wait_clk(HALF);
                sck = 1'b0;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic op1(input logic [7:0] op);
        txb[0] = op;
        xfer(1);
    endtask

    task automatic chk_status(input string tag, input logic [7:0] exp);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
        xfer(3);
        check(tag, rxb[1], exp);
        check(tag, rxb[2], exp);
    endtask

    task automatic chk_err(input string tag);
        check(tag, err_seen, err_exp);
    endtask

    task automatic chk_mem(input string tag, input int addr, input int n);
        txb[0] = 8'h03; txb[1] = 8'h5A; txb[2] = 8'hC3;
        txb[3] = 8'(addr) | HI_BITS;
        for (int k = 0; k < n; k++) txb[4+k] = 8'h00;
        xfer(4 + n);
        for (int k = 0; k < n; k++)
            check(tag, rxb[4+k], model[(addr + k) % DEPTH]);
    endtask

    task automatic prog_cmd(input logic [7:0] op, input int addr, input int n, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2);
        txb[0] = op; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'(addr);
        txb[4] = d0; txb[5] = d1; txb[6] = d2;
        xfer(4 + n);
    endtask

    task automatic mprog(input int addr, input logic [7:0] d);
        model[addr % DEPTH] = model[addr % DEPTH] & d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1: reset state
        chk_status("R1 status after reset", 8'h00);
        chk_mem("R1 array after reset", 0, 4);

        // R2: latch set and clear
        op1(8'h06);
        chk_status("R2 latch set", 8'h02);
        op1(8'h04);
        chk_status("R2 latch cleared", 8'h00);

        // R5: page program while locked writes nothing
        prog_cmd(8'h02, 16, 2, 8'hAA, 8'h55, 8'h00);
        chk_mem("R5 locked program", 16, 2);
        chk_err("R5 no error pulse");

        // R4: page program, AND rule, latch cleared at chip select rise
        op1(8'h06);
        prog_cmd(8'h02, 16, 2, 8'hA5, 8'h3C, 8'h00);
        mprog(16, 8'hA5); mprog(17, 8'h3C);
        chk_status("R4 latch cleared after program", 8'h00);
        chk_mem("R4 programmed data", 16, 2);
        op1(8'h06);
        prog_cmd(8'h02, 16, 1, 8'hF0, 8'h00, 8'h00);
        mprog(16, 8'hF0);
        chk_mem("R4 AND of old and new", 16, 1);

        // R6: auto-increment blocked when latch clear
        prog_cmd(8'hAD, 33, 1, 8'h77, 8'h00, 8'h00);
        err_exp++;
        chk_err("R6 error pulse");
        chk_status("R6 mode not entered", 8'h00);
        chk_mem("R6 array unchanged", 32, 2);

        // R7: first burst, odd address forced even
        op1(8'h06);
        prog_cmd(8'hAD, 33, 2, 8'h11, 8'h22, 8'h00);
        mprog(32, 8'h11); mprog(33, 8'h22);
        chk_status("R7 mode and latch in status", 8'h42);
        chk_err("R7 status read is legal");

        // R8: continuation without address
        txb[0] = 8'hAD; txb[1] = 8'h33; txb[2] = 8'h44;
        xfer(3);
        mprog(34, 8'h33); mprog(35, 8'h44);
        chk_status("R8 mode still set", 8'h42);

        // R9: illegal opcodes inside the mode
        op1(8'h03);
        err_exp++;
        chk_err("R9 read opcode in mode");
        op1(8'h06);
        err_exp++;
        chk_err("R9 write enable opcode in mode");
        chk_status("R9 state kept", 8'h42);

        // R2: write disable ends the mode
        op1(8'h04);
        chk_status("R2 mode cleared by write disable", 8'h00);
        chk_mem("R7 R8 burst data", 32, 4);
        chk_err("R2 write disable legal in mode");

        // R10: burst reaches the top of the array
        op1(8'h06);
        txb[0] = 8'hAD; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'(DEPTH - 4);
        for (int k = 0; k < 6; k++) txb[4+k] = 8'(k + 1);
        xfer(10);
        for (int k = 0; k < 4; k++) mprog(DEPTH - 4 + k, 8'(k + 1));
        chk_status("R10 latch and mode cleared at top", 8'h00);
        chk_mem("R10 no write after wrap", DEPTH - 4, 6);

        // R4 and R3: page program and read wrap at the top
        op1(8'h06);
        prog_cmd(8'h02, DEPTH - 2, 3, 8'h0F, 8'hF0, 8'h5A);
        mprog(DEPTH - 2, 8'h0F); mprog(DEPTH - 1, 8'hF0); mprog(0, 8'h5A);
        chk_mem("R3 R4 wrap across top", DEPTH - 2, 3);

        // R11: aborted command, next byte is an opcode
        txb[0] = 8'h03; txb[1] = 8'h00;
        xfer(2);
        op1(8'h06);
        chk_status("R11 decoder restarted", 8'h02);
        op1(8'h04);
        chk_err("R11 no spurious error");

        // R3: full sweep of the array
        chk_mem("R3 full array sweep", 0, DEPTH);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule